// File: doc/BRIEF.md
# QPSK Quadrature Modulator with Numerically Controlled Oscillator

This block turns a stream of two-bit data symbols into a digital IF sample stream. It makes the carrier with a numerically controlled oscillator. A 32-bit phase accumulator steps by a programmable increment. A programmable offset is added to its value, and the result addresses a sine table that is computed at elaboration. The same table, read a quarter turn further on, gives the cosine. The current dibit chooses one of four quadrature constellation points (I, Q). The block forms I·cos + Q·sin, rounds the sum, saturates it, and presents it as a signed 16-bit sample.

Every arithmetic stage is registered and does one operation per clock, so the block accepts inputs and produces a sample on every clock. Symbols enter through a strobe and are held between strobes. The phase offset can change on any cycle, which gives phase modulation on top of the symbol mapping. An enable input travels down the pipeline beside the data and comes out as the sample-valid flag.

Top module: `qpsk_nco_mod`

## Requirements
- R1: A dibit is mapped to levels (I, Q) of magnitude AMP. Bit 0 set makes I negative, and bit 1 set makes Q negative: 00→(+,+), 01→(−,+), 11→(−,−), 10→(+,−).
- R2: The phase accumulator is 32 bits wide and holds 0 after reset. On every clock edge it adds phase_inc_i, wrapping modulo 2^32.
- R3: The table address is bits [31:22] of (accumulator + phase_off_i) mod 2^32. The sine entry at address a is within 1 LSB of round(32767·sin(2πa/1024)). The cosine is the entry at (a + 256) mod 1024.
- R4: The sample equals round-half-up((I·cos + Q·sin)/2^15), clamped to the range −32768…32767 and never wrapped.
- R5: Inputs sampled on rising edge n give the sample that appears on the outputs just after rising edge n+3. A new sample appears on every clock.
- R6: The symbol register loads sym_i only on an edge where sym_stb_i is high, and the new dibit already applies to that edge's sample. On edges without a strobe, sym_i has no effect and the last loaded dibit is used.
- R7: The phase_off_i sampled on edge n applies to sample n. The phase_inc_i sampled on edge n first changes the phase of sample n+1.
- R8: valid_o after edge n+3 equals en_i sampled on edge n.
- R9: On any edge with rst high, the accumulator, the symbol register (set to 00) and every pipeline register are cleared, so sample_o is 0 and valid_o is 0. For the first three edges after reset, valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phase_inc_i | input | 32 | Phase step added every clock |
| phase_off_i | input | 32 | Phase offset added before the table lookup |
| sym_stb_i | input | 1 | Loads sym_i into the symbol register |
| sym_i | input | 2 | Data dibit |
| en_i | input | 1 | Marks the sample of this cycle as valid |
| sample_o | output | 16 | Signed IF sample |
| valid_o | output | 1 | Sample-valid flag, en_i delayed by four cycles |

## Verification
The first pattern holds the increment at zero and steps the offset through all 1024 table addresses for each of the four dibits. This separates errors in the constellation signs, in the sine/cosine quarter-turn relation and in the address bit selection, and the offset's unused low bits are filled with noise. The second pattern runs several increments, including a negative one and one with low-bit carries, while strobes arrive every few cycles and sym_i is scrambled between them. It tells accumulator wrap and increment timing apart from symbol hold faults. A second instance with full-scale amplitude drives the sum past both rails, which exposes wrap instead of clamp. Enable patterns and a reset in mid-run check the valid lag and the cleared state.

// File: rtl/qmod_pkg.sv
package qmod_pkg;

    localparam int SMP_W   = 16;
    localparam int PH_W_D  = 32;
    localparam int TAB_AW_D = 10;

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef struct packed {
        smp_t sin_v;
        smp_t cos_v;
    } carrier_t;

    typedef struct packed {
        smp_t i_v;
        smp_t q_v;
    } iq_t;

    typedef enum logic [1:0] {
        DIB_PP = 2'b00,
        DIB_MP = 2'b01,
        DIB_PM = 2'b10,
        DIB_MM = 2'b11
    } dibit_e;

    // Constellation point for one dibit; bit 0 flips I, bit 1 flips Q.
    function automatic iq_t map_dibit(dibit_e d, smp_t amp);
        iq_t r;
        case (d)
            DIB_PP:  begin r.i_v = amp;  r.q_v = amp;  end
            DIB_MP:  begin r.i_v = -amp; r.q_v = amp;  end
            DIB_PM:  begin r.i_v = amp;  r.q_v = -amp; end
            default: begin r.i_v = -amp; r.q_v = -amp; end
        endcase
        return r;
    endfunction

    // Fixed-point sine for table slot k of a 2^aw entry table.
    // Quarter-wave folding plus a ninth-order odd polynomial in Q30.
    function automatic smp_t sine_entry(int k, int aw);
        longint one_q, pi_q, x, x2, t, s, fs, v;
        int n, half, qtr, kk;
        n     = 1 << aw;
        half  = n / 2;
        qtr   = n / 4;
        kk    = k % half;
        if (kk > qtr) kk = half - kk;
        one_q = 64'sd1 << 30;
        pi_q  = 64'sd3373259426;
        x     = (longint'(kk) * pi_q) / longint'(half);
        x2    = (x * x) >>> 30;
        t     = one_q - x2 / 72;
        t     = one_q - ((x2 * t) >>> 30) / 42;
        t     = one_q - ((x2 * t) >>> 30) / 20;
        t     = one_q - ((x2 * t) >>> 30) / 6;
        s     = (x * t) >>> 30;
        fs    = (64'sd1 << (SMP_W - 1)) - 1;
        v     = (s * fs + (64'sd1 << 29)) >>> 30;
        if (v > fs) v = fs;
        if ((k % n) >= half) v = -v;
        return smp_t'(v);
    endfunction

endpackage

// File: rtl/qmod_nco.sv
module qmod_nco
    import qmod_pkg::*;
#(
    parameter int PH_W   = PH_W_D,
    parameter int TAB_AW = TAB_AW_D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] inc_i,
    input  logic [PH_W-1:0] off_i,
    output carrier_t        car_o
);

    localparam int TAB_N = 1 << TAB_AW;
    localparam int QTR   = TAB_N / 4;
    localparam logic [TAB_AW-1:0] QTR_STEP = TAB_AW'(QTR);

    typedef logic [TAB_N-1:0][SMP_W-1:0] tab_t;

    function automatic tab_t build_tab();
        tab_t t;
        for (int k = 0; k < TAB_N; k++) begin
            t[k] = sine_entry(k, TAB_AW);
        end
        return t;
    endfunction

    localparam tab_t SIN_TAB = build_tab();

    logic [PH_W-1:0]   acc_q;
    logic [PH_W-1:0]   phase_w;
    logic [TAB_AW-1:0] addr_q;
    logic [TAB_AW-1:0] cos_addr_w;
    carrier_t          car_q;

    assign phase_w    = acc_q + off_i;
    assign cos_addr_w = addr_q + QTR_STEP;

    // Stage 1: accumulate and form the table address.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            addr_q <= '0;
        end else begin
            acc_q  <= acc_q + inc_i;
            addr_q <= phase_w[PH_W-1 -: TAB_AW];
        end
    end

    // Stage 2: sine and quadrature lookups.
    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= '0;
        end else begin
            car_q.sin_v <= smp_t'(SIN_TAB[addr_q]);
            car_q.cos_v <= smp_t'(SIN_TAB[cos_addr_w]);
        end
    end

    assign car_o = car_q;

    // The table is odd-symmetric, so the most negative code never appears.
    p_tab_symm_r3: assert property (@(posedge clk) disable iff (rst)
        (car_q.sin_v != {1'b1, {(SMP_W-1){1'b0}}}) &&
        (car_q.cos_v != {1'b1, {(SMP_W-1){1'b0}}}));

    // When the address did not move, the lookups hold.
    p_tab_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ($stable(addr_q) && !$past(rst)) |=> $stable(car_q));

endmodule

// File: rtl/qmod_mapper.sv
module qmod_mapper
    import qmod_pkg::*;
#(
    parameter int AMP = 16384
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stb_i,
    input  logic [1:0] sym_i,
    output iq_t        iq_o
);

    localparam smp_t AMP_S = smp_t'(AMP);

    dibit_e held_q;
    dibit_e sel_q;
    iq_t    iq_q;

    // Stage 1: symbol register and the dibit for this sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= DIB_PP;
            sel_q  <= DIB_PP;
        end else if (stb_i) begin
            held_q <= dibit_e'(sym_i);
            sel_q  <= dibit_e'(sym_i);
        end else begin
            sel_q  <= held_q;
        end
    end

    // Stage 2: constellation levels, aligned with the table read.
    always_ff @(posedge clk) begin
        if (rst) begin
            iq_q <= '0;
        end else begin
            iq_q <= map_dibit(sel_q, AMP_S);
        end
    end

    assign iq_o = iq_q;

    // Without a strobe the held dibit does not change.
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> (held_q == $past(held_q)));

    // Levels are either cleared or exactly +/-AMP on both rails.
    p_levels_r1: assert property (@(posedge clk) disable iff (rst)
        (iq_q == '0) ||
        (((iq_q.i_v == AMP_S) || (iq_q.i_v == -AMP_S)) &&
         ((iq_q.q_v == AMP_S) || (iq_q.q_v == -AMP_S))));

endmodule

// File: rtl/qmod_mixer.sv
module qmod_mixer
    import qmod_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  iq_t      iq_i,
    input  carrier_t car_i,
    output smp_t     y_o
);

    localparam int PW = 2 * SMP_W;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] HALF = SW'(1) << (SMP_W - 2);
    localparam logic signed [SW-1:0] HI   = {{(SW-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
    localparam logic signed [SW-1:0] LO   = {{(SW-SMP_W+1){1'b1}}, {(SMP_W-1){1'b0}}};

    logic signed [PW-1:0] pi_q;
    logic signed [PW-1:0] pq_q;
    logic signed [SW-1:0] sum_w;
    logic signed [SW-1:0] rnd_w;
    logic signed [SW-1:0] sh_w;
    smp_t                 sat_w;
    smp_t                 y_q;

    // Stage 3: the two products.
    always_ff @(posedge clk) begin
        if (rst) begin
            pi_q <= '0;
            pq_q <= '0;
        end else begin
            pi_q <= $signed(iq_i.i_v) * $signed(car_i.cos_v);
            pq_q <= $signed(iq_i.q_v) * $signed(car_i.sin_v);
        end
    end

    always_comb begin
        sum_w = {pi_q[PW-1], pi_q} + {pq_q[PW-1], pq_q};
        rnd_w = sum_w + HALF;
        sh_w  = rnd_w >>> (SMP_W - 1);
        if (sh_w > HI) begin
            sat_w = HI[SMP_W-1:0];
        end else if (sh_w < LO) begin
            sat_w = LO[SMP_W-1:0];
        end else begin
            sat_w = sh_w[SMP_W-1:0];
        end
    end

    // Stage 4: sum, round and clamp.
    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
        end else begin
            y_q <= sat_w;
        end
    end

    assign y_o = y_q;

    // A positive sum never comes out negative, and a negative one never positive.
    p_no_wrap_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (sum_w > 0) |=> !y_q[SMP_W-1]);
    p_no_wrap_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (sum_w < 0) |=> (y_q[SMP_W-1] || (y_q == '0)));

endmodule

// File: rtl/qpsk_nco_mod.sv
module qpsk_nco_mod
    import qmod_pkg::*;
#(
    parameter int PH_W   = PH_W_D,
    parameter int TAB_AW = TAB_AW_D,
    parameter int AMP    = 16384
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PH_W-1:0]         phase_inc_i,
    input  logic [PH_W-1:0]         phase_off_i,
    input  logic                    sym_stb_i,
    input  logic [1:0]              sym_i,
    input  logic                    en_i,
    output logic signed [SMP_W-1:0] sample_o,
    output logic                    valid_o
);

    localparam int LAT = 4;

    carrier_t       car_w;
    iq_t            iq_w;
    smp_t           y_w;
    logic [LAT-1:0] vld_q;
    logic [2:0]     warm_q;

    qmod_nco #(
        .PH_W   (PH_W),
        .TAB_AW (TAB_AW)
    ) u_nco (
        .clk   (clk),
        .rst   (rst),
        .inc_i (phase_inc_i),
        .off_i (phase_off_i),
        .car_o (car_w)
    );

    qmod_mapper #(
        .AMP (AMP)
    ) u_map (
        .clk   (clk),
        .rst   (rst),
        .stb_i (sym_stb_i),
        .sym_i (sym_i),
        .iq_o  (iq_w)
    );

    qmod_mixer u_mix (
        .clk   (clk),
        .rst   (rst),
        .iq_i  (iq_w),
        .car_i (car_w),
        .y_o   (y_w)
    );

    // Valid flag rides beside the data, one flop per stage.
    generate
        for (genvar g = 0; g < LAT; g++) begin : g_vld
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q[g] <= 1'b0;
                end else begin
                    vld_q[g] <= (g == 0) ? en_i : vld_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    // Edges since reset, saturating; gates the lag check.
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q < 3'(LAT)) begin
            warm_q <= warm_q + 3'd1;
        end
    end

    assign sample_o = y_w;
    assign valid_o  = vld_q[LAT-1];

    p_vld_lag_r8: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 3'(LAT)) |-> (valid_o == $past(en_i, 4)));

    p_vld_cold_r9: assert property (@(posedge clk) disable iff (rst)
        (warm_q < 3'(LAT - 1)) |-> !valid_o);

endmodule

// File: tb/qpsk_nco_mod_bench.sv
module qpsk_nco_mod_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AMP_LO = 16384;
    localparam int AMP_HI = 32767;
    localparam int TOL = 3;
    localparam real PI = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        inc = '0;
    logic [31:0]        off = '0;
    logic               stb = 1'b0;
    logic [1:0]         sym = '0;
    logic               en  = 1'b0;
    logic signed [15:0] y_lo, y_hi;
    logic               v_lo, v_hi;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Bench model state
    logic [31:0] m_acc;
    logic [1:0]  m_sym;
    int          m_n;
    int          h_lo [8];
    int          h_hi [8];
    bit          h_v  [8];
    string       cur_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    qpsk_nco_mod #(.AMP(AMP_LO)) u_qpsk_nco_mod (
        .clk(clk), .rst(rst), .phase_inc_i(inc), .phase_off_i(off),
        .sym_stb_i(stb), .sym_i(sym), .en_i(en),
        .sample_o(y_lo), .valid_o(v_lo)
    );

    qpsk_nco_mod #(.AMP(AMP_HI)) u_qpsk_nco_mod_hi (
        .clk(clk), .rst(rst), .phase_inc_i(inc), .phase_off_i(off),
        .sym_stb_i(stb), .sym_i(sym), .en_i(en),
        .sample_o(y_hi), .valid_o(v_hi)
    );

    function automatic int model_out(int addr, logic [1:0] s, int amp);
        real ang, sv, cv, tot;
        int iv, qv, r;
        ang = 2.0 * PI * real'(addr) / 1024.0;
        sv  = 32767.0 * $sin(ang);
        cv  = 32767.0 * $cos(ang);
        iv  = s[0] ? -amp : amp;
        qv  = s[1] ? -amp : amp;
        tot = real'(iv) * cv + real'(qv) * sv;
        r   = $rtoi($floor(tot / 32768.0 + 0.5));
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit near(int a, int b);
        return (a - b <= TOL) && (b - a <= TOL);
    endfunction

    // One clock: drive at negedge, model the edge, compare at the next negedge.
    task automatic tick(input logic r, input logic [31:0] pinc, input logic [31:0] poff,
                        input logic pstb, input logic [1:0] psym, input logic pen);
        logic [31:0] ph;
        int          idx;
        rst = r; inc = pinc; off = poff; stb = pstb; sym = psym; en = pen;
        @(posedge clk);
        if (r) begin
            m_acc = '0;
            m_sym = 2'b00;
            m_n   = 0;
        end else begin
            if (pstb) m_sym = psym;
            ph  = m_acc + poff;
            idx = m_n % 8;
            h_lo[idx] = model_out(int'(ph[31:22]), m_sym, AMP_LO);
            h_hi[idx] = model_out(int'(ph[31:22]), m_sym, AMP_HI);
            h_v[idx]  = pen;
            m_acc = m_acc + pinc;
            m_n++;
        end
        @(negedge clk);
        if (r) begin
            // R9: cleared state
            check(y_lo == 0 && y_hi == 0, "R9", "sample in reset", int'(y_lo), 0);
            check(!v_lo && !v_hi, "R9", "valid in reset", int'(v_lo), 0);
        end else if (m_n < 4) begin
            check(!v_lo && !v_hi, "R9", "valid before pipeline fills", int'(v_lo), 0);
        end else begin
            idx = (m_n - 4) % 8;
            // R5 R8: the flag and the data of edge n show up after edge n+3
            check(v_lo == h_v[idx] && v_hi == h_v[idx], "R8", "valid lag",
                  int'(v_lo), int'(h_v[idx]));
            if (h_v[idx]) begin
                check(near(int'(y_lo), h_lo[idx]), cur_req, "sample", int'(y_lo), h_lo[idx]);
                check(near(int'(y_hi), h_hi[idx]), "R4", "full-scale sample",
                      int'(y_hi), h_hi[idx]);
            end
        end
    endtask

    initial begin
        logic [31:0] incs [4];
        incs[0] = 32'h0040_0000;
        incs[1] = 32'hFFC0_0000;
        incs[2] = 32'h0950_0309;
        incs[3] = 32'h1234_5678;

        cur_req = "R9";
        repeat (3) tick(1'b1, '0, '0, 1'b0, 2'b00, 1'b0);

        // Pattern 1: R1 R3 R5 R7, every dibit against every table address.
        cur_req = "R1 R3 R5";
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 1024; a++) begin
                tick(1'b0, 32'd0, (32'(a) << 22) | 32'($urandom_range(0, 32'h3F_FFFF)),
                     (a == 0), 2'(s), 1'b1);
            end
        end

        // Pattern 2: R2 R6 R7, running increments with sparse strobes.
        cur_req = "R2 R6 R7";
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 400; k++) begin
                tick(1'b0, incs[c], (k % 50 < 25) ? 32'd0 : 32'h4000_0000,
                     (k % 7 == 0), 2'($urandom_range(0, 3)), 1'b1);
            end
        end

        // Pattern 3: R8, enable pattern through the pipeline.
        cur_req = "R8";
        for (int k = 0; k < 200; k++) begin
            tick(1'b0, 32'h0123_4567, 32'd0, (k % 11 == 0), 2'(k % 4),
                 ((k % 3) == 0) || ((k % 13) < 4));
        end

        // Mid-run reset: R9, then R2 restart from zero phase.
        cur_req = "R9";
        repeat (2) tick(1'b1, 32'h0123_4567, 32'd0, 1'b1, 2'b11, 1'b1);
        cur_req = "R2 R9";
        for (int k = 0; k < 40; k++) begin
            tick(1'b0, 32'h0200_0000, 32'd0, 1'b0, 2'b10, 1'b1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule